// File: doc/BRIEF.md
# Per-Bit Delay Window Edge Tracker

This block finds the passing window of every data bit in a group by stepping a delay setting upward and asking an outside test engine for a verdict at each step. A sweep runs in two phases. The left phase moves the data-side delay, and the right phase moves the strobe-side delay. Each step drives a delay value with a one-cycle apply strobe, then raises a test request. When the engine answers, it returns an overall verdict and a pass bit for each data bit.

The block keeps a sticky mask of every bit that has passed at least once. A sweep ends early when the current verdict is a failure and the sticky mask matches the mask of expected bits. Each bit keeps a signed left edge and a signed right edge. When a failure is seen before the first pass, the opposite field gets a negative marker of -(d+1). Later logic uses this marker to compute the window centre.

When both phases are done, the block reports a result code and stops. Any position of the edge array can be read at any time through an index port.

Top module: `edge_window_tracker`

## Requirements
- R1: After reset, and again in the cycle after a start is accepted, every left and right edge entry reads the sentinel DMAX+1. While idle, no test request and no apply strobe are asserted.
- R2: Each phase steps its delay upward from 0, one step at a time. Each step gives a one-cycle apply strobe with the delay value, then asserts the test request until test_done is seen. Left-phase steps drive delay_sel=0 and right-phase steps drive delay_sel=1.
- R3: After each verdict, the sticky mask becomes the OR of itself and the pass vector. A phase stops at that step only when test_ok=0 and the sticky mask equals full_mask. Otherwise it continues up to and including DMAX.
- R4: On a step that does not stop, each passing bit stores the step value d. In the left phase it goes to the left edge, and in the right phase it goes to the right edge.
- R5: In the left phase, a bit that fails on a non-stopping step while its left edge is still the sentinel gets its right edge set to -(d+1).
- R6: After the left phase, a single apply strobe drives delay 0 with delay_sel=0. Then any bit whose left edge is the sentinel has its right edge set back to the sentinel.
- R7: Before the right phase, the sticky mask is rebuilt. In read mode (write_mode=0) it holds the bits whose left and right edges are both valid. In write mode it holds the bits whose left edge is valid.
- R8: In the right phase, a bit that fails on a non-stopping step with no right edge yet behaves as follows. At d=0, if its left edge is valid, its right edge becomes -1. In every other case its left edge becomes -(d+1).
- R9: In write mode, if the right phase stops at d=0, every bit with a valid left edge and a sentinel right edge gets its right edge set to -1.
- R10: At the end, a one-cycle done pulse presents fail_code. The code is i+1 for the lowest bit i whose left or right edge is still the sentinel, and 0 if no such bit exists.
- R11: rd_left and rd_right return the stored edges of the bit at rd_idx as two's-complement numbers that are one bit wider than needed for DMAX+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a two-phase sweep when idle |
| write_mode | input | 1 | 1 selects the write-mode sticky and stop rules |
| full_mask | input | NBITS | Bits expected to pass at least once |
| delay_val | output | DW | Delay setting being applied |
| delay_sel | output | 1 | 0 for the data-side delay, 1 for the strobe-side delay |
| delay_apply | output | 1 | One-cycle strobe to load delay_val |
| test_req | output | 1 | Request a test at the applied delay |
| test_done | input | 1 | One-cycle verdict strobe from the engine |
| test_ok | input | 1 | Overall verdict, 1 when the test counts as passing |
| test_pass | input | NBITS | Pass bit for each data bit |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| fail_code | output | CW | 0 on success, else lowest unpaired bit index plus one |
| rd_idx | input | IW | Edge array read index |
| rd_left | output | EW | Signed left edge of bit rd_idx |
| rd_right | output | EW | Signed right edge of bit rd_idx |

## Verification
The assertions assume the following about the test engine. It raises test_done for exactly one cycle and only while test_req is high. It raises start only while busy is low. The bench engine meets this by answering every request with a single-cycle done at the next falling edge, then clearing it. The bench raises start only after the previous done pulse. The per-bit pass vectors come from randomly placed windows for each phase, some of them empty. These are mixed with directed cases that force an early stop, a right-phase stop at d=0 in each mode, and a bit that never passes.

// File: rtl/edge_tracker_pkg.sv
// Package: shared state and per-bit operation encodings for the window edge tracker.
// Assumes: nothing beyond the enumeration widths chosen here.
package edge_tracker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_WAIT,
        ST_SCAN,
        ST_ZERO,
        ST_FIX,
        ST_MARK,
        ST_CHECK
    } trk_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SCAN,
        OP_FIX,
        OP_MARK
    } edge_op_t;

endpackage

// File: rtl/edge_rule.sv
// Module: combinational update rule for one bit's edge pair.
// Chooses the new left/right edge for the bit being visited, from the current
// operation, the phase, the bit's pass result and the step value.
// Assumes: the edges use EW-bit two's complement and the sentinel is DMAX+1.
module edge_rule
    import edge_tracker_pkg::*;
#(
    parameter int DMAX = 31,
    parameter int DW   = 5,
    parameter int EW   = 7
) (
    input  edge_op_t               op,
    input  logic                   right_ph,
    input  logic                   pass_bit,
    input  logic [DW-1:0]          step,
    input  logic signed [EW-1:0]   cur_l,
    input  logic signed [EW-1:0]   cur_r,
    output logic signed [EW-1:0]   nxt_l,
    output logic signed [EW-1:0]   nxt_r
);
    localparam logic signed [EW-1:0] SENT = EW'(DMAX + 1);
    localparam logic signed [EW-1:0] MINUS_ONE = '1;

    logic signed [EW-1:0] step_s;
    logic signed [EW-1:0] premark;
    logic                 l_none;
    logic                 r_none;

    // Derive the signed step, its negative pre-mark and the sentinel flags
    always_comb begin
        step_s  = EW'(step);
        premark = -(step_s + EW'(1));
        l_none  = (cur_l == SENT);
        r_none  = (cur_r == SENT);
    end

    // Apply the per-operation edge update rule
    always_comb begin
        nxt_l = cur_l;
        nxt_r = cur_r;
        unique case (op)
            OP_SCAN: begin
                if (!right_ph) begin
                    if (pass_bit)    nxt_l = step_s;
                    else if (l_none) nxt_r = premark;
                end else begin
                    if (pass_bit) begin
                        nxt_r = step_s;
                    end else if (r_none) begin
                        if ((step == '0) && !l_none) nxt_r = MINUS_ONE;
                        else                         nxt_l = premark;
                    end
                end
            end
            OP_FIX:  if (l_none && !r_none) nxt_r = SENT;
            OP_MARK: if (r_none && !l_none) nxt_r = MINUS_ONE;
            default: ;
        endcase
    end
endmodule

// File: rtl/edge_regfile.sv
// Module: storage of the left/right edge pair of every bit.
// One write port and two read ports: one for the sequencer, one external.
// Assumes: widx and ridx_a stay below NBITS; ridx_b may not, and then reads the sentinel.
module edge_regfile #(
    parameter int NBITS = 8,
    parameter int DMAX  = 31,
    parameter int EW    = 7,
    parameter int IW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 we,
    input  logic [IW-1:0]        widx,
    input  logic signed [EW-1:0] wl,
    input  logic signed [EW-1:0] wr,
    input  logic [IW-1:0]        ridx_a,
    output logic signed [EW-1:0] la,
    output logic signed [EW-1:0] ra,
    input  logic [IW-1:0]        ridx_b,
    output logic signed [EW-1:0] lb,
    output logic signed [EW-1:0] rb
);
    localparam logic signed [EW-1:0] SENT = EW'(DMAX + 1);

    logic signed [EW-1:0] left_q  [NBITS];
    logic signed [EW-1:0] right_q [NBITS];

    // Reset or clear every entry to the sentinel, else write one entry
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int k = 0; k < NBITS; k++) begin
                left_q[k]  <= SENT;
                right_q[k] <= SENT;
            end
        end else if (we) begin
            left_q[widx]  <= wl;
            right_q[widx] <= wr;
        end
    end

    // Read both ports, guarding the external index range
    always_comb begin
        la = left_q[ridx_a];
        ra = right_q[ridx_a];
        if (int'(ridx_b) < NBITS) begin
            lb = left_q[ridx_b];
            rb = right_q[ridx_b];
        end else begin
            lb = SENT;
            rb = SENT;
        end
    end
endmodule

// File: rtl/sweep_fsm.sv
// Module: sequencer for the two-phase delay sweep.
// Steps the delay, handshakes with the test engine, keeps the sticky mask,
// visits bits one per clock (LSB first on scans, MSB first on the rebuild)
// and produces the final result code.
// Assumes: test_done is a one-cycle strobe given only while test_req is high.
module sweep_fsm
    import edge_tracker_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int DMAX  = 31,
    parameter int DW    = 5,
    parameter int EW    = 7,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 write_mode,
    input  logic [NBITS-1:0]     full_mask,
    input  logic                 test_done,
    input  logic                 test_ok,
    input  logic [NBITS-1:0]     test_pass,
    input  logic signed [EW-1:0] cur_l,
    input  logic signed [EW-1:0] cur_r,
    input  logic signed [EW-1:0] nxt_r,
    output logic [DW-1:0]        delay_val,
    output logic                 delay_sel,
    output logic                 delay_apply,
    output logic                 test_req,
    output logic                 busy,
    output logic                 done,
    output logic [CW-1:0]        fail_code,
    output logic                 clear,
    output logic                 we,
    output logic [IW-1:0]        idx,
    output edge_op_t             op,
    output logic                 pass_bit
);
    localparam logic signed [EW-1:0] SENT = EW'(DMAX + 1);
    localparam logic [IW-1:0]        LAST = IW'(NBITS - 1);
    localparam logic [DW-1:0]        DTOP = DW'(DMAX);

    trk_state_t       state;
    logic [DW-1:0]    step;
    logic             right_ph;
    logic             mode_q;
    logic [NBITS-1:0] mask_q;
    logic [NBITS-1:0] sticky;
    logic [NBITS-1:0] pass_sr;
    logic [CW-1:0]    code_q;
    logic             done_q;
    logic [NBITS-1:0] sticky_n;
    logic             stop;
    logic             keep;
    logic             bad;

    // Stop decision, rebuild keep bit and unpaired-edge flag
    always_comb begin
        sticky_n = sticky | test_pass;
        stop     = !test_ok && (sticky_n == mask_q);
        keep     = mode_q ? (cur_l != SENT) : ((cur_l != SENT) && (nxt_r != SENT));
        bad      = (cur_l == SENT) || (cur_r == SENT);
    end

    // Main sequencing register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            right_ph <= 1'b0;
            mode_q   <= 1'b0;
            mask_q   <= '0;
            sticky   <= '0;
            pass_sr  <= '0;
            idx      <= '0;
            code_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    sticky   <= '0;
                    right_ph <= 1'b0;
                    step     <= '0;
                    mode_q   <= write_mode;
                    mask_q   <= full_mask;
                    code_q   <= '0;
                    state    <= ST_APPLY;
                end
                ST_APPLY: state <= ST_WAIT;
                ST_WAIT: if (test_done) begin
                    sticky  <= sticky_n;
                    pass_sr <= test_pass;
                    idx     <= '0;
                    if (!stop)                          state <= ST_SCAN;
                    else if (!right_ph)                 begin step <= '0; state <= ST_ZERO; end
                    else if (mode_q && (step == '0))    state <= ST_MARK;
                    else                                state <= ST_CHECK;
                end
                ST_SCAN: begin
                    pass_sr <= pass_sr >> 1;
                    if (idx == LAST) begin
                        idx <= '0;
                        if (step == DTOP) begin
                            if (!right_ph) begin step <= '0; state <= ST_ZERO; end
                            else           state <= ST_CHECK;
                        end else begin
                            step  <= step + DW'(1);
                            state <= ST_APPLY;
                        end
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                ST_ZERO: begin
                    sticky <= '0;
                    idx    <= LAST;
                    state  <= ST_FIX;
                end
                ST_FIX: begin
                    sticky <= (sticky << 1) | NBITS'(keep);
                    if (idx == '0) begin
                        right_ph <= 1'b1;
                        step     <= '0;
                        state    <= ST_APPLY;
                    end else begin
                        idx <= idx - IW'(1);
                    end
                end
                ST_MARK: begin
                    if (idx == LAST) begin idx <= '0; state <= ST_CHECK; end
                    else idx <= idx + IW'(1);
                end
                ST_CHECK: begin
                    if (bad) begin
                        code_q <= CW'(idx) + CW'(1);
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (idx == LAST) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state
    always_comb begin
        delay_val   = step;
        delay_sel   = right_ph;
        delay_apply = (state == ST_APPLY) || (state == ST_ZERO);
        test_req    = (state == ST_WAIT);
        busy        = (state != ST_IDLE);
        done        = done_q;
        fail_code   = code_q;
        clear       = (state == ST_IDLE) && start;
        we          = (state == ST_SCAN) || (state == ST_FIX) || (state == ST_MARK);
        pass_bit    = pass_sr[0];
        unique case (state)
            ST_SCAN: op = OP_SCAN;
            ST_FIX:  op = OP_FIX;
            ST_MARK: op = OP_MARK;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/edge_window_tracker.sv
// Module: top of the per-bit delay window edge tracker.
// Ties the sequencer, the per-bit rule and the edge storage together.
// Assumes: NBITS >= 2; the test engine keeps the single-strobe handshake.
module edge_window_tracker
    import edge_tracker_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int DMAX  = 31,
    parameter int DW    = $clog2(DMAX + 1),
    parameter int EW    = $clog2(DMAX + 2) + 1,
    parameter int IW    = $clog2(NBITS),
    parameter int CW    = $clog2(NBITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 write_mode,
    input  logic [NBITS-1:0]     full_mask,
    output logic [DW-1:0]        delay_val,
    output logic                 delay_sel,
    output logic                 delay_apply,
    output logic                 test_req,
    input  logic                 test_done,
    input  logic                 test_ok,
    input  logic [NBITS-1:0]     test_pass,
    output logic                 busy,
    output logic                 done,
    output logic [CW-1:0]        fail_code,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [EW-1:0] rd_left,
    output logic signed [EW-1:0] rd_right
);
    logic                 clear;
    logic                 we;
    logic [IW-1:0]        idx;
    edge_op_t             op;
    logic                 pass_bit;
    logic signed [EW-1:0] cur_l;
    logic signed [EW-1:0] cur_r;
    logic signed [EW-1:0] nxt_l;
    logic signed [EW-1:0] nxt_r;

    sweep_fsm #(
        .NBITS(NBITS), .DMAX(DMAX), .DW(DW), .EW(EW), .IW(IW), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .full_mask(full_mask), .test_done(test_done), .test_ok(test_ok),
        .test_pass(test_pass), .cur_l(cur_l), .cur_r(cur_r), .nxt_r(nxt_r),
        .delay_val(delay_val), .delay_sel(delay_sel), .delay_apply(delay_apply),
        .test_req(test_req), .busy(busy), .done(done), .fail_code(fail_code),
        .clear(clear), .we(we), .idx(idx), .op(op), .pass_bit(pass_bit)
    );

    edge_rule #(
        .DMAX(DMAX), .DW(DW), .EW(EW)
    ) u_rule (
        .op(op), .right_ph(delay_sel), .pass_bit(pass_bit), .step(delay_val),
        .cur_l(cur_l), .cur_r(cur_r), .nxt_l(nxt_l), .nxt_r(nxt_r)
    );

    edge_regfile #(
        .NBITS(NBITS), .DMAX(DMAX), .EW(EW), .IW(IW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .we(we), .widx(idx),
        .wl(nxt_l), .wr(nxt_r), .ridx_a(idx), .la(cur_l), .ra(cur_r),
        .ridx_b(rd_idx), .lb(rd_left), .rb(rd_right)
    );
endmodule

// File: rtl/edge_window_tracker_chk.sv
// Module: protocol and range checks for the window edge tracker, bound to the top.
// Assumes: the engine answers each request with one single-cycle test_done.
module edge_window_tracker_chk #(
    parameter int NBITS = 8,
    parameter int DMAX  = 31,
    parameter int DW    = 5,
    parameter int EW    = 7,
    parameter int CW    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic [CW-1:0]        fail_code,
    input logic                 test_req,
    input logic                 test_done,
    input logic                 delay_apply,
    input logic                 delay_sel,
    input logic [DW-1:0]        delay_val,
    input logic signed [EW-1:0] rd_left,
    input logic signed [EW-1:0] rd_right
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!test_req && !delay_apply));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_done) |=> test_req);

    assert_apply_then_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_apply && delay_sel) |=> test_req);

    assert_right_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delay_sel) |-> (delay_apply && (delay_val == '0)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && (int'(fail_code) <= NBITS)));

    assert_edge_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_left) >= -(DMAX + 1)) && (int'(rd_left) <= DMAX + 1) &&
        (int'(rd_right) >= -(DMAX + 1)) && (int'(rd_right) <= DMAX + 1));
endmodule

bind edge_window_tracker edge_window_tracker_chk #(
    .NBITS(NBITS), .DMAX(DMAX), .DW(DW), .EW(EW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail_code(fail_code),
    .test_req(test_req), .test_done(test_done), .delay_apply(delay_apply),
    .delay_sel(delay_sel), .delay_val(delay_val), .rd_left(rd_left),
    .rd_right(rd_right)
);

// File: tb/edge_window_tracker_test.sv
`timescale 1ns/1ps
// Bench: random and directed window sweeps against a software model of the rules.
module edge_window_tracker_test;
    localparam int NB   = 8;
    localparam int DMAX = 31;
    localparam int DW   = 5;
    localparam int EW   = 7;
    localparam int IW   = 3;
    localparam int CW   = 4;
    localparam int SENT = DMAX + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 write_mode = 1'b0;
    logic [NB-1:0]        full_mask = '1;
    logic [DW-1:0]        delay_val;
    logic                 delay_sel;
    logic                 delay_apply;
    logic                 test_req;
    logic                 test_done = 1'b0;
    logic                 test_ok = 1'b0;
    logic [NB-1:0]        test_pass = '0;
    logic                 busy;
    logic                 done;
    logic [CW-1:0]        fail_code;
    logic [IW-1:0]        rd_idx = '0;
    logic signed [EW-1:0] rd_left;
    logic signed [EW-1:0] rd_right;

    int checks = 0;
    int fails  = 0;

    // window tables: [bit] for left phase and right phase
    int lo_l [NB];
    int hi_l [NB];
    int lo_r [NB];
    int hi_r [NB];

    int act_log [128];
    int act_n = 0;
    int exp_log [128];
    int exp_n;
    int exp_l [NB];
    int exp_r [NB];
    int exp_fc;

    always #4 clk = ~clk;

    edge_window_tracker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .full_mask(full_mask), .delay_val(delay_val), .delay_sel(delay_sel),
        .delay_apply(delay_apply), .test_req(test_req), .test_done(test_done),
        .test_ok(test_ok), .test_pass(test_pass), .busy(busy), .done(done),
        .fail_code(fail_code), .rd_idx(rd_idx), .rd_left(rd_left),
        .rd_right(rd_right)
    );

    function automatic logic [NB-1:0] pass_vec(input int ph, input int d);
        logic [NB-1:0] v;
        for (int i = 0; i < NB; i++)
            v[i] = (ph == 0) ? (d >= lo_l[i] && d <= hi_l[i])
                             : (d >= lo_r[i] && d <= hi_r[i]);
        return v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Test engine: logs applies, answers each request with a one-cycle done
    int cur_d = 0;
    int cur_s = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (delay_apply) begin
                cur_d = int'(delay_val);
                cur_s = int'(delay_sel);
                if (act_n < 128) act_log[act_n] = cur_d + 64 * cur_s;
                act_n++;
            end
            if (test_done) begin
                test_done = 1'b0;
            end else if (test_req) begin
                test_pass = pass_vec(cur_s, cur_d);
                test_ok   = (test_pass & full_mask) != '0;
                test_done = 1'b1;
            end
        end
    end

    // Reference model of the sweep rules
    task automatic model(input logic wm, input logic [NB-1:0] m);
        logic [NB-1:0] st;
        logic [NB-1:0] pv;
        logic          ok;
        exp_n = 0;
        for (int i = 0; i < NB; i++) begin exp_l[i] = SENT; exp_r[i] = SENT; end
        st = '0;
        for (int d = 0; d <= DMAX; d++) begin
            exp_log[exp_n++] = d;
            pv = pass_vec(0, d);
            ok = (pv & m) != '0;
            st = st | pv;
            if (!ok && st == m) break;
            for (int i = 0; i < NB; i++)
                if (pv[i]) exp_l[i] = d;
                else if (exp_l[i] == SENT) exp_r[i] = -(d + 1);
        end
        exp_log[exp_n++] = 0;
        st = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (exp_l[i] == SENT && exp_r[i] != SENT) exp_r[i] = SENT;
            st = st << 1;
            if (wm) st[0] = (exp_l[i] != SENT);
            else    st[0] = (exp_l[i] != SENT) && (exp_r[i] != SENT);
        end
        for (int d = 0; d <= DMAX; d++) begin
            exp_log[exp_n++] = d + 64;
            pv = pass_vec(1, d);
            ok = (pv & m) != '0;
            st = st | pv;
            if (!ok && st == m) begin
                if (wm && d == 0)
                    for (int i = 0; i < NB; i++)
                        if (exp_r[i] == SENT && exp_l[i] != SENT) exp_r[i] = -1;
                break;
            end
            for (int i = 0; i < NB; i++) begin
                if (pv[i]) exp_r[i] = d;
                else if (exp_r[i] == SENT) begin
                    if (d == 0 && exp_l[i] != SENT) exp_r[i] = -1;
                    else exp_l[i] = -(d + 1);
                end
            end
        end
        exp_fc = 0;
        for (int i = 0; i < NB; i++)
            if (exp_l[i] == SENT || exp_r[i] == SENT) begin exp_fc = i + 1; break; end
    endtask

    task automatic run_case(input logic wm, input logic [NB-1:0] m);
        model(wm, m);
        @(negedge clk);
        write_mode = wm;
        full_mask  = m;
        act_n      = 0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: edges cleared in the cycle after start
        rd_idx = '0;
        #0.5;
        check("R1", "left[0] after start", int'(rd_left), SENT);
        rd_idx = IW'(NB - 1);
        #0.5;
        check("R1", "right[top] after start", int'(rd_right), SENT);
        while (!done) @(negedge clk);
        check("R10", "fail_code", int'(fail_code), exp_fc);
        // R2/R3/R6: applied delay sequence and phase lengths
        check("R3", "apply count", act_n, exp_n);
        for (int k = 0; k < exp_n && k < act_n && k < 128; k++)
            if (act_log[k] != exp_log[k]) begin
                check("R2", $sformatf("apply %0d", k), act_log[k], exp_log[k]);
                break;
            end
        for (int i = 0; i < NB; i++) begin
            rd_idx = IW'(i);
            #0.2;
            check("R4/R5/R8 R11", $sformatf("left[%0d]", i), int'(rd_left), exp_l[i]);
            check("R6/R8/R9 R11", $sformatf("right[%0d]", i), int'(rd_right), exp_r[i]);
        end
    endtask

    task automatic set_all(input int ll, input int lh, input int rl, input int rh);
        for (int i = 0; i < NB; i++) begin
            lo_l[i] = ll; hi_l[i] = lh; lo_r[i] = rl; hi_r[i] = rh;
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(1234));
        set_all(100, 0, 100, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "test_req after reset", int'(test_req), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "left[0] after reset", int'(rd_left), SENT);

        // R3/R4: left window 0..5 stops early at 6; right window 0..3
        set_all(0, 5, 0, 3);
        run_case(1'b0, '1);
        // R5/R8: left window mid-range gives pre-marks; right fails at d=0
        set_all(4, 9, 2, 6);
        run_case(1'b0, '1);
        // R9: write mode, right phase stops at d=0
        set_all(0, 5, 3, 8);
        run_case(1'b1, '1);
        // R7: read mode, same windows (no stop at d=0)
        run_case(1'b0, '1);
        // R10: bit 3 never passes
        set_all(2, 7, 1, 4);
        lo_l[3] = 100; hi_l[3] = 0; lo_r[3] = 100; hi_r[3] = 0;
        run_case(1'b0, '1);
        // R6: bit 5 fails left entirely but passes right
        set_all(3, 6, 0, 2);
        lo_l[5] = 100; hi_l[5] = 0;
        run_case(1'b1, '1);

        // Random windows, modes and masks
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < NB; i++) begin
                lo_l[i] = $urandom_range(0, DMAX);
                hi_l[i] = lo_l[i] + $urandom_range(0, 12);
                lo_r[i] = $urandom_range(0, 10);
                hi_r[i] = lo_r[i] + $urandom_range(0, 12);
                if ($urandom_range(0, 9) == 0) begin lo_l[i] = 100; hi_l[i] = 0; end
                if ($urandom_range(0, 9) == 0) begin lo_r[i] = 100; hi_r[i] = 0; end
            end
            run_case(1'($urandom_range(0, 1)),
                     ($urandom_range(0, 3) == 0) ? NB'($urandom) : '1);
        end
        summary();
        $finish;
    end
endmodule